// File: doc/BRIEF.md
# Intrusion Detect Status Latch

This block watches an active-low chassis-intrusion input. It records an intrusion in a status bit that lives in a slow real-time-clock domain, and it can raise a one-cycle interrupt request to a system-management handler. The input is brought into the RTC domain through a synchronizer. It then passes a glitch filter, which must see a run of consecutive active samples before the status bit is set.

Software clears the status bit by writing a 1 from the bus clock domain. A toggle handshake carries that write into the RTC domain. The clear follows an unusual rule. If the filtered input is still active when the clear request arrives, the bit stays set, a clear stays pending, and a new interrupt request is raised at once. The pending clear takes effect on the first RTC edge at which the filtered input has gone inactive, with no second write. A two-bit select field decides whether interrupts are produced at all.

Top module: `intr_latch`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `statusBit`, `irqPulse` and `wrBusy` are all 0.
- R2: `statusBit` becomes 1 only if the synchronized input is active for at least FILTER_LEN consecutive RTC samples. A low pulse on `intruderN` lasting FILTER_LEN-1 RTC periods never sets it.
- R3: A bus write with `wrStrobe`=1 and `wrData`=1, made while the filtered input is inactive, clears `statusBit` within 6 RTC periods.
- R4: A clear write that arrives while the filtered input is still active leaves `statusBit` at 1.
- R5: After a clear write that was deferred under R4, `statusBit` returns to 0 within 6 RTC periods of `intruderN` going high, with no further write.
- R6: With `irqSel`=2'b01, each 0-to-1 transition of `statusBit` gives exactly one `irqPulse`, which is one RTC period wide. A clear deferred under R4 gives exactly one further pulse.
- R7: With `irqSel` set to 2'b00, 2'b10 or 2'b11, `irqPulse` never asserts. This holds for setting, for deferred clears, and for later release-and-reassert cycles of the input.
- R8: A bus write with `wrStrobe`=1 and `wrData`=0 has no effect: a set `statusBit` stays 1.
- R9: `wrBusy` is 1 on the bus cycle after an accepted write and returns to 0 once the RTC domain has taken the request. Writes made while `wrBusy`=1 are not accepted.
- R10: Once set, `statusBit` stays 1 after the input returns high, until a clear write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock for register writes |
| rtcClk | input | 1 | Slow real-time clock; the status bit lives here |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrStrobe | input | 1 | One-cycle write strobe for the status bit (busClk) |
| wrData | input | 1 | Write data; 1 requests a clear, 0 is ignored |
| wrBusy | output | 1 | A clear request is in flight to the RTC domain |
| intruderN | input | 1 | Asynchronous active-low intrusion input |
| irqSel | input | 2 | Interrupt select: 2'b01 enables, other codes disable |
| statusBit | output | 1 | Intrusion status (rtcClk domain) |
| irqPulse | output | 1 | One-RTC-period interrupt request |

## Verification
Low pulses on the intrusion input are swept in length from one RTC period up to two periods past the filter length. Each length is followed by a clear, so the bench locates the exact length at which the filter accepts and separates an off-by-one filter from a correct one. The input is also held active across a clear write and released later, under every select code. This shows a deferred clear apart from an ordinary sticky clear, and an enabled select apart from the disabling ones. Writes with data 0, and the plain sticky case with no write, show whether the bit clears only when it should.

// File: rtl/intr_latch_pkg.sv
package intr_latch_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_IRQ  = 2'b01,
    SEL_RSV2 = 2'b10,
    SEL_RSV3 = 2'b11
  } irqSel_e;

  typedef struct packed {
    logic setStatus;
    logic clearStatus;
    logic armPending;
    logic dropPending;
    logic fireIrq;
  } latchStrobes_t;

endpackage

// File: rtl/intr_clr_xfer.sv
module intr_clr_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic busClk,
  input  logic rtcClk,
  input  logic rstN,
  input  logic wrStrobe,
  input  logic wrData,
  output logic wrBusy,
  output logic clrReq
);

  logic reqTog;
  logic [SYNC_STAGES-1:0] ackSync;
  logic [SYNC_STAGES-1:0] reqSync;
  logic reqSeen;
  logic accept;

  assign wrBusy = reqTog != ackSync[SYNC_STAGES-1];
  assign accept = wrStrobe && wrData && !wrBusy;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      reqTog  <= 1'b0;
      ackSync <= '0;
    end else begin
      reqTog  <= reqTog ^ accept;
      ackSync <= {ackSync[SYNC_STAGES-2:0], reqSeen};
    end
  end

  always_ff @(posedge rtcClk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      reqSeen <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_STAGES-2:0], reqTog};
      reqSeen <= reqSync[SYNC_STAGES-1];
    end
  end

  assign clrReq = reqSync[SYNC_STAGES-1] ^ reqSeen;

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge busClk) disable iff (!rstN)
    (wrBusy && wrStrobe) |=> $stable(reqTog)) else $error("busy write accepted"); // R9

  AST_CLR_REQ_SINGLE: assert property (@(posedge rtcClk) disable iff (!rstN)
    clrReq |=> !clrReq) else $error("clear request longer than one cycle"); // R3

endmodule

// File: rtl/intr_latch_ctrl.sv
module intr_latch_ctrl
  import intr_latch_pkg::*;
(
  input  logic          filtActive,
  input  logic          statusQ,
  input  logic          pendingQ,
  input  logic          clrReq,
  input  logic [1:0]    irqSel,
  output latchStrobes_t strobes
);

  logic irqEnabled;
  logic setEdge;
  logic deferredClear;

  assign irqEnabled    = irqSel_e'(irqSel) == SEL_IRQ;
  assign setEdge       = filtActive && !statusQ;
  assign deferredClear = clrReq && statusQ && filtActive;

  always_comb begin
    strobes             = '0;
    strobes.setStatus   = filtActive;
    strobes.clearStatus = !filtActive && statusQ && (pendingQ || clrReq);
    strobes.armPending  = deferredClear;
    strobes.dropPending = strobes.clearStatus;
    strobes.fireIrq     = irqEnabled && (setEdge || deferredClear);
  end

endmodule

// File: rtl/intr_latch_dp.sv
module intr_latch_dp
  import intr_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 33
) (
  input  logic          rtcClk,
  input  logic          rstN,
  input  logic          intruderN,
  input  logic [1:0]    irqSel,
  input  latchStrobes_t strobes,
  output logic          filtActive,
  output logic          statusQ,
  output logic          pendingQ,
  output logic          irqQ
);

  localparam int CNT_W = $clog2(FILTER_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILTER_LEN);

  logic [SYNC_STAGES-1:0] inSync;
  logic activeSync;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge rtcClk or negedge rstN) begin
    if (!rstN) inSync <= '0;
    else       inSync <= {inSync[SYNC_STAGES-2:0], !intruderN};
  end
  assign activeSync = inSync[SYNC_STAGES-1];

  always_ff @(posedge rtcClk or negedge rstN) begin
    if (!rstN)                 runCnt <= '0;
    else if (!activeSync)      runCnt <= '0;
    else if (runCnt != CNT_MAX) runCnt <= runCnt + 1'b1;
  end
  assign filtActive = runCnt == CNT_MAX;

  always_ff @(posedge rtcClk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= 1'b0;
      pendingQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      if (strobes.setStatus)        statusQ <= 1'b1;
      else if (strobes.clearStatus) statusQ <= 1'b0;
      if (strobes.armPending)       pendingQ <= 1'b1;
      else if (strobes.dropPending) pendingQ <= 1'b0;
      irqQ <= strobes.fireIrq;
    end
  end

  AST_FILTER_NEEDS_INPUT: assert property (@(posedge rtcClk) disable iff (!rstN)
    filtActive |-> $past(activeSync)) else $error("filter active without input"); // R2

  AST_SET_ON_FILTER: assert property (@(posedge rtcClk) disable iff (!rstN)
    filtActive |=> statusQ) else $error("status not set"); // R2

  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge rtcClk) disable iff (!rstN)
    (statusQ && filtActive) |=> statusQ) else $error("status cleared under active input"); // R4

  AST_CLEAR_ONLY_INACTIVE: assert property (@(posedge rtcClk) disable iff (!rstN)
    $fell(statusQ) |-> !$past(filtActive)) else $error("status fell while active"); // R5

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge rtcClk) disable iff (!rstN)
    (irqSel != 2'b01) |=> !irqQ) else $error("irq with select off"); // R7

endmodule

// File: rtl/intr_latch.sv
module intr_latch
  import intr_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 33
) (
  input  logic       busClk,
  input  logic       rtcClk,
  input  logic       rstN,
  input  logic       wrStrobe,
  input  logic       wrData,
  output logic       wrBusy,
  input  logic       intruderN,
  input  logic [1:0] irqSel,
  output logic       statusBit,
  output logic       irqPulse
);

  latchStrobes_t strobes;
  logic clrReq;
  logic filtActive;
  logic statusQ;
  logic pendingQ;
  logic irqQ;

  intr_clr_xfer #(.SYNC_STAGES(SYNC_STAGES)) xfer_i (
    .busClk(busClk), .rtcClk(rtcClk), .rstN(rstN),
    .wrStrobe(wrStrobe), .wrData(wrData),
    .wrBusy(wrBusy), .clrReq(clrReq)
  );

  intr_latch_ctrl ctrl_i (
    .filtActive(filtActive), .statusQ(statusQ), .pendingQ(pendingQ),
    .clrReq(clrReq), .irqSel(irqSel), .strobes(strobes)
  );

  intr_latch_dp #(.SYNC_STAGES(SYNC_STAGES), .FILTER_LEN(FILTER_LEN)) dp_i (
    .rtcClk(rtcClk), .rstN(rstN), .intruderN(intruderN), .irqSel(irqSel),
    .strobes(strobes), .filtActive(filtActive), .statusQ(statusQ),
    .pendingQ(pendingQ), .irqQ(irqQ)
  );

  assign statusBit = statusQ;
  assign irqPulse  = irqQ;

endmodule

// File: tb/intr_latch_tb_top.sv
`timescale 1ns/1ps
module intr_latch_tb_top;

  localparam int FLEN = 4;

  logic busClk = 1'b0;
  logic rtcClk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0;
  logic wrData = 1'b0;
  logic intruderN = 1'b1;
  logic [1:0] irqSel = 2'b01;
  logic wrBusy, statusBit, irqPulse;

  int checks = 0;
  int fails = 0;
  int irqCnt = 0;
  bit done = 0;

  always #2.5 busClk = ~busClk;
  always #30 rtcClk = ~rtcClk;

  intr_latch #(.SYNC_STAGES(2), .FILTER_LEN(FLEN)) dut_i (
    .busClk(busClk), .rtcClk(rtcClk), .rstN(rstN),
    .wrStrobe(wrStrobe), .wrData(wrData), .wrBusy(wrBusy),
    .intruderN(intruderN), .irqSel(irqSel),
    .statusBit(statusBit), .irqPulse(irqPulse)
  );

  always @(negedge rtcClk) if (rstN && irqPulse) irqCnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rtcWait(int n);
    repeat (n) @(negedge rtcClk);
  endtask

  task automatic pulseIntr(int n);
    @(negedge rtcClk);
    intruderN = 1'b0;
    repeat (n) @(negedge rtcClk);
    intruderN = 1'b1;
  endtask

  task automatic busWrite(logic d);
    @(negedge busClk);
    wrStrobe = 1'b1;
    wrData = d;
    @(negedge busClk);
    wrStrobe = 1'b0;
    wrData = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int c0;
    rtcWait(3);
    check("R1 status in reset", statusBit, 0);
    check("R1 irq in reset", irqPulse, 0);
    check("R1 busy in reset", wrBusy, 0);
    rstN = 1'b1;
    rtcWait(4);
    check("R1 status after reset", statusBit, 0);

    // R2 / R6 / R3 / R9: pulse length sweep with enabled select
    irqSel = 2'b01;
    for (int n = 1; n <= FLEN + 2; n++) begin
      c0 = irqCnt;
      pulseIntr(n);
      rtcWait(6);
      check("R2 filter length", statusBit, (n >= FLEN) ? 1 : 0);
      check("R6 one irq per set", irqCnt - c0, (n >= FLEN) ? 1 : 0);
      busWrite(1'b1);
      check("R9 busy after write", wrBusy, 1);
      busWrite(1'b1);
      rtcWait(6);
      check("R3 clear when inactive", statusBit, 0);
      check("R9 busy released", wrBusy, 0);
    end

    // R10 sticky, R8 data-0 write ignored
    pulseIntr(FLEN + 1);
    rtcWait(20);
    check("R10 sticky after release", statusBit, 1);
    busWrite(1'b0);
    rtcWait(6);
    check("R8 write of 0 ignored", statusBit, 1);
    check("R8 no busy for data 0", wrBusy, 0);
    busWrite(1'b1);
    rtcWait(6);
    check("R3 clear", statusBit, 0);

    // R4 / R5 / R6 / R7 across all select codes
    for (int s = 0; s < 4; s++) begin
      int en;
      en = (s == 1) ? 1 : 0;
      irqSel = 2'(s);
      c0 = irqCnt;
      @(negedge rtcClk);
      intruderN = 1'b0;
      rtcWait(FLEN + 4);
      check("R2 set under hold", statusBit, 1);
      check(en ? "R6 irq on set" : "R7 no irq on set", irqCnt - c0, en);
      busWrite(1'b1);
      rtcWait(8);
      check("R4 stays set while active", statusBit, 1);
      check(en ? "R6 irq re-raised" : "R7 no irq on deferred clear", irqCnt - c0, 2 * en);
      intruderN = 1'b1;
      rtcWait(6);
      check("R5 auto clear on release", statusBit, 0);
      c0 = irqCnt;
      pulseIntr(FLEN + 1);
      rtcWait(3);
      pulseIntr(FLEN + 1);
      rtcWait(6);
      check(en ? "R6 one irq for reassert" : "R7 no irq on reassert", irqCnt - c0, en);
      busWrite(1'b1);
      rtcWait(6);
      check("R3 clear after reassert", statusBit, 0);
    end

    finishRun();
  end

endmodule